// File: doc/BRIEF.md
# Sideband Signal Serializer

This block carries up to sixteen slow side-band status lines to a processor over a single wire. A two-bit selection input decides which of the lines take part. At every clock the block compares the selected, masked set of lines with the set it captured on the previous clock. When they differ, it sends one complete framed word over the serial line, one bit per clock. Lines that are not selected are forced to zero, both in the comparison and in the transmitted word.

A frame is twenty bits long: a low start pair, then the sixteen data bits from the highest line down to line 0, then a high stop pair. The line rests high between frames, and a `busy` flag marks the clocks that carry a frame. If the selection changes while a frame is going out, the change is remembered. A fresh frame then follows the last stop bit with no gap and carries the values present at that moment.

Top module: `sbser_top`

## Requirements
- R1: While no frame is being sent, `ser_out` is 1 and `busy` is 0.
- R2: When the masked input value at a rising clock edge differs from the value captured at the previous edge, and no frame is in progress, a frame starts at that edge. Its first bit is on `ser_out` from that edge onward, and each later edge advances one bit.
- R3: Frame bits 1 and 2, the first two sent, are both 0.
- R4: Frame bits 3 to 18 carry masked data bit 15 first, down to data bit 0 last.
- R5: Frame bits 19 and 20, the last two sent, are both 1.
- R6: With `mode` = 00, only `sig_in[0]` is selected. Changes on bits 15:1 send no frame, and those positions go out as 0.
- R7: With `mode` = 01, bits 7:0 are selected. Changes on bits 15:8 send no frame, and those positions go out as 0.
- R8: With `mode` = 10, all sixteen bits are selected.
- R9: `mode` = 11 selects exactly as `mode` = 00.
- R10: A change of the masked value during a frame is held. The next frame begins on the edge right after the last stop bit and carries the masked value present at that edge.
- R11: `busy` is 1 on exactly the clocks that carry frame bits, 20 per frame, with no drop between back-to-back frames.
- R12: Synchronous active-low reset ends any frame. It returns the outputs to the idle state and clears the captured value to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sig_in | input | 16 | Side-band input lines |
| mode | input | 2 | Selection of participating lines |
| ser_out | output | 1 | Serial frame output, idles high |
| busy | output | 1 | High while frame bits are on `ser_out` |

## Verification
The bench builds the block with its default parameters: sixteen lines, a low group of eight for mode 01, and two start and two stop bits. This gives the full twenty-bit frame. At this size every selection mode can be told apart from the others, since bit 0, bits 7:0 and bits 15:8 are distinct groups. A change placed a few clocks into a frame shows the held-change path and the seamless follow-on frame, seen as one forty-bit stream. A reset applied mid-frame shows that the frame is abandoned.

// File: rtl/sbser_pkg.sv
// Shared definitions for the sideband serializer.
package sbser_pkg;
    typedef enum logic [1:0] {
        SB_MODE_SUSP = 2'b00,
        SB_MODE_LOW  = 2'b01,
        SB_MODE_ALL  = 2'b10,
        SB_MODE_ALT  = 2'b11
    } sb_mode_e;
endpackage

// File: rtl/sbser_select.sv
// Masks the input lines according to the selection mode.
// Assumes line 0 is always selected; unselected lines read as 0.
module sbser_select
    import sbser_pkg::*;
#(
    parameter int NUM_SIG = 16,
    parameter int LOW_W   = 8
) (
    input  logic [NUM_SIG-1:0] sig_in,
    input  logic [1:0]         mode,
    output logic [NUM_SIG-1:0] masked
);
    sb_mode_e mode_e;
    assign mode_e = sb_mode_e'(mode);

    for (genvar i = 0; i < NUM_SIG; i++) begin : g_bit
        // Per-line enable: line 0 always, low group in LOW mode, all in ALL mode.
        always_comb begin
            if (i == 0)
                masked[i] = sig_in[i];
            else if (mode_e == SB_MODE_ALL)
                masked[i] = sig_in[i];
            else if (mode_e == SB_MODE_LOW && i < LOW_W)
                masked[i] = sig_in[i];
            else
                masked[i] = 1'b0;
        end
    end
endmodule

// File: rtl/sbser_detect.sv
// Detects a change of the masked value and holds it until a frame load.
// Assumes load is asserted only while trigger is high.
module sbser_detect #(
    parameter int NUM_SIG = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SIG-1:0] masked,
    input  logic               load,
    output logic               trigger
);
    logic [NUM_SIG-1:0] prev_q;
    logic               pend_q;
    logic               change;

    assign change  = (masked != prev_q);
    assign trigger = change | pend_q;

    // Capture the masked value every clock for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= masked;
    end

    // Remember a change until the shifter takes a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (load)   pend_q <= 1'b0;
        else if (change) pend_q <= 1'b1;
    end
endmodule

// File: rtl/sbser_shift.sv
// Frame shifter: loads start bits, data and stop bits, then sends them MSB first.
// Assumes data is stable in the cycle where load is high.
module sbser_shift #(
    parameter int DATA_W  = 16,
    parameter int START_W = 2,
    parameter int STOP_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trigger,
    input  logic [DATA_W-1:0] data,
    output logic              load,
    output logic              ser_out,
    output logic              busy
);
    localparam int FRAME_W = START_W + DATA_W + STOP_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] ONE_CNT   = CNT_W'(1);

    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   left_q;
    logic [FRAME_W-1:0] frame;

    assign frame   = {{START_W{1'b0}}, data, {STOP_W{1'b1}}};
    assign busy    = (left_q != '0);
    assign load    = trigger && (left_q == '0 || left_q == ONE_CNT);
    assign ser_out = busy ? shreg_q[FRAME_W-1] : 1'b1;

    // Load a frame when idle or at the last bit, else shift one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            left_q  <= '0;
        end else if (load) begin
            shreg_q <= frame;
            left_q  <= FRAME_CNT;
        end else if (busy) begin
            shreg_q <= shreg_q << 1;
            left_q  <= left_q - ONE_CNT;
        end
    end
endmodule

// File: rtl/sbser_top.sv
// Sideband serializer top: select, change detect, frame shifter.
// Assumes inputs are synchronous to clk.
module sbser_top #(
    parameter int NUM_SIG = 16,
    parameter int LOW_W   = 8,
    parameter int START_W = 2,
    parameter int STOP_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SIG-1:0] sig_in,
    input  logic [1:0]         mode,
    output logic               ser_out,
    output logic               busy
);
    logic [NUM_SIG-1:0] masked;
    logic               trigger;
    logic               load;

    sbser_select #(.NUM_SIG(NUM_SIG), .LOW_W(LOW_W)) u_sel (
        .sig_in (sig_in),
        .mode   (mode),
        .masked (masked)
    );

    sbser_detect #(.NUM_SIG(NUM_SIG)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .masked  (masked),
        .load    (load),
        .trigger (trigger)
    );

    sbser_shift #(.DATA_W(NUM_SIG), .START_W(START_W), .STOP_W(STOP_W)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (trigger),
        .data    (masked),
        .load    (load),
        .ser_out (ser_out),
        .busy    (busy)
    );
endmodule

// File: rtl/sbser_chk.sv
// Property checker for sbser_top, attached by bind.
// Tracks the bit position within frames with its own counter.
module sbser_chk #(
    parameter int NUM_SIG = 16,
    parameter int START_W = 2,
    parameter int STOP_W  = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ser_out,
    input logic busy,
    input logic trigger
);
    localparam int FRAME_W = START_W + NUM_SIG + STOP_W;
    localparam int POS_W   = $clog2(FRAME_W + 1);

    logic [POS_W-1:0] pos_q;

    // Bit position inside the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  pos_q <= '0;
        else if (!busy)                              pos_q <= '0;
        else if (pos_q == POS_W'(FRAME_W - 1))       pos_q <= '0;
        else                                         pos_q <= pos_q + POS_W'(1);
    end

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ser_out);

    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pos_q < POS_W'(START_W)) |-> !ser_out);

    p_stop_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pos_q >= POS_W'(FRAME_W - STOP_W)) |-> ser_out);

    p_no_cut_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pos_q != POS_W'(FRAME_W - 1)) |=> busy);

    p_start_on_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trigger && !busy) |=> busy);

    p_follow_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trigger && busy && pos_q == POS_W'(FRAME_W - 1)) |=> busy);
endmodule

bind sbser_top sbser_chk #(.NUM_SIG(NUM_SIG), .START_W(START_W), .STOP_W(STOP_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_out (ser_out),
    .busy    (busy),
    .trigger (trigger)
);

// File: tb/sim_sbser_top.sv
// Directed bench for sbser_top: one task per scenario.
module sim_sbser_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sig_in = '0;
    logic [1:0]  mode = 2'b00;
    logic        ser_out;
    logic        busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sbser_top u0 (.clk(clk), .rst_n(rst_n), .sig_in(sig_in), .mode(mode),
                  .ser_out(ser_out), .busy(busy));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sample n bits at the negedge after each rising edge; returns bits and busy-all-high.
    task automatic grab(input int n, output logic [39:0] bits, output bit all_busy);
        bits = '0;
        all_busy = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            bits = {bits[38:0], ser_out};
            if (!busy) all_busy = 1'b0;
        end
    endtask

    // Expect one frame with given data, then idle.
    task automatic expect_frame(input string req, input logic [15:0] data);
        logic [39:0] b;
        bit          ab;
        grab(20, b, ab);
        chk(b[19:0] == {2'b00, data, 2'b11}, req, 64'(b[19:0]), 64'({2'b00, data, 2'b11}));
        chk(ab, {req, " R11 busy"}, 64'(ab), 64'd1);
        grab(1, b, ab);
        chk(!busy && ser_out, {req, " R1 idle after"}, {busy, ser_out}, 64'b01);
    endtask

    task automatic expect_quiet(input string req, input int cyc);
        bit ok = 1'b1;
        for (int i = 0; i < cyc; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (busy || !ser_out) ok = 1'b0;
        end
        chk(ok, req, 64'(ok), 64'd1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(!busy && ser_out, "R12 R1 reset idle", {busy, ser_out}, 64'b01);
        expect_quiet("R1 stays idle", 5);
    endtask

    task automatic t_mode_susp();
        sig_in = 16'hFFFE;
        expect_quiet("R6 upper lines ignored", 30);
        @(negedge clk); sig_in = 16'hFFFF;
        expect_frame("R6 R2 R3 R4 R5 bit0 only", 16'h0001);
        sig_in = 16'h0000;
        expect_frame("R6 bit0 falls", 16'h0000);
    endtask

    task automatic t_mode_low();
        mode = 2'b01;
        expect_quiet("R7 mode change with zero inputs", 5);
        sig_in = 16'hA5C3;
        expect_frame("R7 low group", 16'h00C3);
        sig_in = 16'h5AC3;
        expect_quiet("R7 upper byte ignored", 25);
        sig_in = 16'h0000;
        expect_frame("R7 low group clears", 16'h0000);
    endtask

    task automatic t_mode_all();
        mode = 2'b10;
        sig_in = 16'h8001;
        expect_frame("R8 all lines", 16'h8001);
        sig_in = 16'h1234;
        expect_frame("R8 R4 msb first", 16'h1234);
        sig_in = 16'h0000;
        expect_frame("R8 clear", 16'h0000);
    endtask

    task automatic t_mode_alt();
        mode = 2'b11;
        sig_in = 16'hFFFE;
        expect_quiet("R9 mode 11 ignores upper", 25);
        sig_in = 16'h0001;
        expect_frame("R9 mode 11 bit0", 16'h0001);
    endtask

    task automatic t_back_to_back();
        logic [39:0] b;
        bit          ab;
        mode = 2'b10;
        expect_quiet("R8 mode change same masked value", 5);
        sig_in = 16'h00F0;
        b = '0;
        ab = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            @(negedge clk);
            b = {b[38:0], ser_out};
            if (!busy) ab = 1'b0;
            if (i == 4) sig_in = 16'h0F00;
        end
        chk(b == {2'b00, 16'h00F0, 2'b11, 2'b00, 16'h0F00, 2'b11}, "R10 held change follow-on",
            64'(b), 64'({2'b00, 16'h00F0, 2'b11, 2'b00, 16'h0F00, 2'b11}));
        chk(ab, "R11 busy through back-to-back", 64'(ab), 64'd1);
        @(posedge clk); @(negedge clk);
        chk(!busy && ser_out, "R1 idle after pair", {busy, ser_out}, 64'b01);
    endtask

    task automatic t_reset_mid();
        sig_in = 16'h0000;
        repeat (6) begin @(posedge clk); @(negedge clk); end
        chk(busy, "R2 frame in progress before reset", 64'(busy), 64'd1);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(!busy && ser_out, "R12 reset ends frame", {busy, ser_out}, 64'b01);
        rst_n = 1'b1;
        expect_quiet("R12 captured value cleared to zero", 25);
        sig_in = 16'h0100;
        expect_frame("R12 frame after reset", 16'h0100);
    endtask

    initial begin
        t_reset();
        t_mode_susp();
        t_mode_low();
        t_mode_all();
        t_mode_alt();
        t_back_to_back();
        t_reset_mid();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule